// File: doc/BRIEF.md
# Segmented Address Translation Unit

This unit maps a small virtual address space of 16 KB onto a physical address space through three segments: code, heap and stack. Every segment has its own register set: a physical base, a size, a flag that says whether the segment grows toward higher or lower addresses, and read, write and execute permission bits. The two top bits of a virtual address pick the segment. The remaining bits are the offset inside a window of the largest possible segment size, which is 4 KB with the default widths.

A lookup presents a virtual address and an access kind. One cycle later the unit returns either a physical address or a single fault code, qualified by a response strobe. The segment registers are loaded through a write port that only accepts writes in privileged mode. A write attempted from user mode is dropped, and a one-cycle error pulse is raised.

Top module: `segxl_unit`

## Requirements
- R1: After reset, rsp_valid and cfg_err are low. Every segment has base 0, size 0, upward growth and no permissions, so any mapped access returns the bounds fault.
- R2: vaddr[13:12] selects the segment: 00 code, 01 heap, 11 stack. The value 10 returns fault code 1 (unmapped).
- R3: In an upward segment, with offset = vaddr[11:0], the access fits when offset < size. The physical address is then (base + offset) modulo 2^PA_W.
- R4: In a downward segment, let mag = 4096 - offset. The access fits when mag <= size. The physical address is then (base - mag) modulo 2^PA_W.
- R5: An access that does not fit returns fault code 2 (bounds).
- R6: Permission bit 0 allows reads (acc 00), bit 1 allows writes (acc 01) and bit 2 allows instruction fetches (acc 10). The access kind 11 is never allowed. A denied access returns fault code 3 (protection).
- R7: When several faults apply, unmapped wins over bounds, and bounds wins over protection. Fault code 0 means success.
- R8: Each request with req_valid high produces exactly one response, with rsp_valid high in the following cycle. rsp_valid is low in every cycle that follows a cycle without a request.
- R9: A configuration write with priv_mode high loads base, size, growth flag and permissions of the segment chosen by cfg_sel (0 code, 1 heap, 2 stack). A write with priv_mode low leaves all registers unchanged and sets cfg_err for the next cycle only.
- R10: A privileged write to cfg_sel 3 changes no register and raises no error.
- R11: When a response carries a nonzero fault code, rsp_paddr is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| priv_mode | input | 1 | 1 = privileged mode, used to qualify configuration writes |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | VA_W | Virtual address |
| req_acc | input | 2 | Access kind: 00 read, 01 write, 10 fetch, 11 invalid |
| cfg_we | input | 1 | Segment register write strobe |
| cfg_sel | input | 2 | Target segment of the write |
| cfg_base | input | PA_W | New physical base |
| cfg_size | input | VA_W-1 | New size in bytes (0 to 4096) |
| cfg_down | input | 1 | New growth flag, 1 = grows downward |
| cfg_prot | input | 3 | New permissions {x, w, r} |
| rsp_valid | output | 1 | Response strobe |
| rsp_paddr | output | PA_W | Physical address, 0 on a fault |
| rsp_fault | output | 2 | 0 ok, 1 unmapped, 2 bounds, 3 protection |
| cfg_err | output | 1 | Privilege violation on a configuration write |

## Verification
The bench builds the unit with VA_W = 14 and PA_W = 16. With these values the 4 KB segment limit and both edges of each bound check can be reached exactly: an offset equal to the size, and a downward distance equal to or one past the size. The 16-bit physical space is small enough that bases near the top or bottom make the addition and the subtraction wrap. This exercises the modulo behaviour of both growth directions.

// File: rtl/segxl_pkg.sv
package segxl_pkg;
  localparam int NSEG = 3;

  localparam logic [1:0] ACC_RD  = 2'd0;
  localparam logic [1:0] ACC_WR  = 2'd1;
  localparam logic [1:0] ACC_FE  = 2'd2;

  localparam logic [1:0] FLT_NONE  = 2'd0;
  localparam logic [1:0] FLT_UNMAP = 2'd1;
  localparam logic [1:0] FLT_BOUND = 2'd2;
  localparam logic [1:0] FLT_PROT  = 2'd3;

  // permission bit positions
  localparam int PROT_R = 0;
  localparam int PROT_W = 1;
  localparam int PROT_X = 2;

  function automatic logic prot_allows(input logic [2:0] prot, input logic [1:0] acc);
    case (acc)
      ACC_RD:  return prot[PROT_R];
      ACC_WR:  return prot[PROT_W];
      ACC_FE:  return prot[PROT_X];
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/segxl_regs.sv
module segxl_regs #(
  parameter int PA_W = 16,
  parameter int SZ_W = 13,
  parameter int NSEG = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       priv_mode,
  input  logic                       cfg_we,
  input  logic [1:0]                 cfg_sel,
  input  logic [PA_W-1:0]            cfg_base,
  input  logic [SZ_W-1:0]            cfg_size,
  input  logic                       cfg_down,
  input  logic [2:0]                 cfg_prot,
  output logic [NSEG-1:0][PA_W-1:0]  seg_base,
  output logic [NSEG-1:0][SZ_W-1:0]  seg_size,
  output logic [NSEG-1:0]            seg_down,
  output logic [NSEG-1:0][2:0]       seg_prot,
  output logic                       wr_accept,
  output logic                       wr_reject
);
  logic sel_in_range;

  assign sel_in_range = (32'(cfg_sel) < NSEG);
  assign wr_accept    = cfg_we && priv_mode && sel_in_range;
  assign wr_reject    = cfg_we && !priv_mode;

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        seg_base[g] <= '0;
        seg_size[g] <= '0;
        seg_down[g] <= 1'b0;
        seg_prot[g] <= 3'b000;
      end else if (wr_accept && (32'(cfg_sel) == g)) begin
        seg_base[g] <= cfg_base;
        seg_size[g] <= cfg_size;
        seg_down[g] <= cfg_down;
        seg_prot[g] <= cfg_prot;
      end
    end
  end
endmodule

// File: rtl/segxl_xlate.sv
module segxl_xlate
  import segxl_pkg::*;
#(
  parameter int VA_W = 14,
  parameter int PA_W = 16,
  parameter int SZ_W = 13
) (
  input  logic [VA_W-1:0]            vaddr,
  input  logic [1:0]                 acc,
  input  logic [NSEG-1:0][PA_W-1:0]  seg_base,
  input  logic [NSEG-1:0][SZ_W-1:0]  seg_size,
  input  logic [NSEG-1:0]            seg_down,
  input  logic [NSEG-1:0][2:0]       seg_prot,
  output logic [PA_W-1:0]            paddr,
  output logic [1:0]                 fault,
  output logic                       mapped,
  output logic                       in_bounds,
  output logic                       allowed
);
  localparam int OFF_W   = VA_W - 2;
  localparam int MAX_SEG = 1 << OFF_W;

  function automatic logic [SZ_W-1:0] down_dist(input logic [OFF_W-1:0] off);
    return SZ_W'(MAX_SEG) - {1'b0, off};
  endfunction

  function automatic logic up_fits(input logic [OFF_W-1:0] off, input logic [SZ_W-1:0] size);
    return {1'b0, off} < size;
  endfunction

  function automatic logic down_fits(input logic [OFF_W-1:0] off, input logic [SZ_W-1:0] size);
    return down_dist(off) <= size;
  endfunction

  logic [1:0]      top;
  logic [OFF_W-1:0] off;
  logic [1:0]      idx;
  logic [PA_W-1:0] base;
  logic [SZ_W-1:0] size;
  logic            down;
  logic [2:0]      prot;
  logic [PA_W-1:0] addr_calc;

  assign top = vaddr[VA_W-1 -: 2];
  assign off = vaddr[OFF_W-1:0];

  always_comb begin
    mapped = 1'b1;
    idx    = 2'd0;
    case (top)
      2'b00:   idx = 2'd0;
      2'b01:   idx = 2'd1;
      2'b11:   idx = 2'd2;
      default: mapped = 1'b0;
    endcase
  end

  assign base = seg_base[idx];
  assign size = seg_size[idx];
  assign down = seg_down[idx];
  assign prot = seg_prot[idx];

  assign in_bounds = down ? down_fits(off, size) : up_fits(off, size);
  assign allowed   = prot_allows(prot, acc);
  assign addr_calc = down ? (base - PA_W'(down_dist(off))) : (base + PA_W'(off));

  always_comb begin
    if (!mapped)         fault = FLT_UNMAP;
    else if (!in_bounds) fault = FLT_BOUND;
    else if (!allowed)   fault = FLT_PROT;
    else                 fault = FLT_NONE;
  end

  assign paddr = (fault == FLT_NONE) ? addr_calc : '0;
endmodule

// File: rtl/segxl_unit.sv
module segxl_unit
  import segxl_pkg::*;
#(
  parameter int VA_W = 14,
  parameter int PA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              priv_mode,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [1:0]        req_acc,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [PA_W-1:0]   cfg_base,
  input  logic [VA_W-2:0]   cfg_size,
  input  logic              cfg_down,
  input  logic [2:0]        cfg_prot,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [1:0]        rsp_fault,
  output logic              cfg_err
);
  localparam int SZ_W = VA_W - 1;

  logic [NSEG-1:0][PA_W-1:0] seg_base;
  logic [NSEG-1:0][SZ_W-1:0] seg_size;
  logic [NSEG-1:0]           seg_down;
  logic [NSEG-1:0][2:0]      seg_prot;
  logic                      wr_accept;
  logic                      wr_reject;
  logic [PA_W-1:0]           xl_paddr;
  logic [1:0]                xl_fault;
  logic                      xl_mapped;
  logic                      xl_in_bounds;
  logic                      xl_allowed;

  segxl_regs #(.PA_W(PA_W), .SZ_W(SZ_W), .NSEG(NSEG)) u_regs (
    .clk(clk), .rst_n(rst_n), .priv_mode(priv_mode),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_base(cfg_base),
    .cfg_size(cfg_size), .cfg_down(cfg_down), .cfg_prot(cfg_prot),
    .seg_base(seg_base), .seg_size(seg_size), .seg_down(seg_down),
    .seg_prot(seg_prot), .wr_accept(wr_accept), .wr_reject(wr_reject)
  );

  segxl_xlate #(.VA_W(VA_W), .PA_W(PA_W), .SZ_W(SZ_W)) u_xlate (
    .vaddr(req_vaddr), .acc(req_acc),
    .seg_base(seg_base), .seg_size(seg_size), .seg_down(seg_down),
    .seg_prot(seg_prot), .paddr(xl_paddr), .fault(xl_fault),
    .mapped(xl_mapped), .in_bounds(xl_in_bounds), .allowed(xl_allowed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= FLT_NONE;
      cfg_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      cfg_err   <= wr_reject;
      if (req_valid) begin
        rsp_paddr <= xl_paddr;
        rsp_fault <= xl_fault;
      end
    end
  end
endmodule

// File: rtl/segxl_chk.sv
module segxl_chk #(
  parameter int VA_W = 14,
  parameter int PA_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            priv_mode,
  input logic            req_valid,
  input logic [VA_W-1:0] req_vaddr,
  input logic            cfg_we,
  input logic            rsp_valid,
  input logic [PA_W-1:0] rsp_paddr,
  input logic [1:0]      rsp_fault,
  input logic            cfg_err,
  input logic            wr_accept
);
  // R8
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R8
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R11
  fault_no_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == '0));

  // R2
  unmapped_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_vaddr[VA_W-1 -: 2] == 2'b10) |=> (rsp_fault == 2'd1));

  // R9
  user_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !priv_mode) |=> cfg_err);

  // R9
  err_only_on_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && !priv_mode) |=> !cfg_err);

  // R9
  accept_needs_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |-> (priv_mode && cfg_we));
endmodule

bind segxl_unit segxl_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .priv_mode(priv_mode), .req_valid(req_valid),
  .req_vaddr(req_vaddr), .cfg_we(cfg_we), .rsp_valid(rsp_valid),
  .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .cfg_err(cfg_err),
  .wr_accept(wr_accept)
);

// File: tb/segxl_unit_bench.sv
`timescale 1ns/1ps
module segxl_unit_bench;
  localparam int VA_W = 14;
  localparam int PA_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic priv_mode = 1'b0;
  logic req_valid = 1'b0;
  logic [VA_W-1:0] req_vaddr = '0;
  logic [1:0] req_acc = 2'd0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [PA_W-1:0] cfg_base = '0;
  logic [VA_W-2:0] cfg_size = '0;
  logic cfg_down = 1'b0;
  logic [2:0] cfg_prot = 3'b000;
  logic rsp_valid;
  logic [PA_W-1:0] rsp_paddr;
  logic [1:0] rsp_fault;
  logic cfg_err;

  always #4 clk = ~clk;

  segxl_unit #(.VA_W(VA_W), .PA_W(PA_W)) u_segxl_unit (
    .clk(clk), .rst_n(rst_n), .priv_mode(priv_mode), .req_valid(req_valid),
    .req_vaddr(req_vaddr), .req_acc(req_acc), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_base(cfg_base), .cfg_size(cfg_size),
    .cfg_down(cfg_down), .cfg_prot(cfg_prot), .rsp_valid(rsp_valid),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .cfg_err(cfg_err)
  );

  typedef struct {
    int   paddr;
    int   fault;
    string tag;
  } exp_t;

  exp_t sb_q[$];
  int total = 0;
  int bad = 0;

  int m_base[3];
  int m_size[3];
  bit m_down[3];
  int m_prot[3];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input int va, input int acc, input string tag);
    exp_t e;
    int top, s, off, mag;
    bit fits, ok_acc;
    e.tag = tag;
    e.paddr = 0;
    top = (va >> 12) & 3;
    off = va & 12'hFFF;
    if (top == 2) begin e.fault = 1; return e; end
    s = (top == 3) ? 2 : top;
    if (m_down[s]) begin
      mag = 4096 - off;
      fits = (mag <= m_size[s]);
    end else begin
      mag = 0;
      fits = (off < m_size[s]);
    end
    if (!fits) begin e.fault = 2; return e; end
    ok_acc = (acc == 0) ? m_prot[s][0] : (acc == 1) ? m_prot[s][1] :
             (acc == 2) ? m_prot[s][2] : 1'b0;
    if (!ok_acc) begin e.fault = 3; return e; end
    e.fault = 0;
    e.paddr = m_down[s] ? ((m_base[s] - mag) & 16'hFFFF) : ((m_base[s] + off) & 16'hFFFF);
    return e;
  endfunction

  task automatic access(input int va, input int acc, input string tag);
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = VA_W'(va);
    req_acc   = 2'(acc);
    sb_q.push_back(model(va, acc, tag));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  task automatic cfg(input bit priv, input int sel, input int base, input int size,
                     input bit down, input int prot, input string tag);
    bit exp_err;
    @(negedge clk);
    req_valid = 1'b0;
    priv_mode = priv;
    cfg_we = 1'b1;
    cfg_sel = 2'(sel);
    cfg_base = PA_W'(base);
    cfg_size = (VA_W-1)'(size);
    cfg_down = down;
    cfg_prot = 3'(prot);
    exp_err = !priv;
    if (priv && sel < 3) begin
      m_base[sel] = base; m_size[sel] = size; m_down[sel] = down; m_prot[sel] = prot;
    end
    @(negedge clk);
    cfg_we = 1'b0;
    priv_mode = 1'b0;
    check(cfg_err == exp_err, tag, int'(cfg_err), int'(exp_err));
    @(negedge clk);
    check(cfg_err == 1'b0, {tag, " err clears"}, int'(cfg_err), 0);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R8 response without request", 1, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(int'(rsp_fault) == e.fault, {e.tag, " fault"}, int'(rsp_fault), e.fault);
        check(int'(rsp_paddr) == e.paddr, {e.tag, " paddr"}, int'(rsp_paddr), e.paddr);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) begin
      m_base[i] = 0; m_size[i] = 0; m_down[i] = 0; m_prot[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R1 rsp_valid after reset", int'(rsp_valid), 0);
    check(cfg_err == 1'b0, "R1 cfg_err after reset", int'(cfg_err), 0);
    access(16'h0000, 0, "R1 code empty");
    access(16'h1004, 1, "R1 heap empty");
    access(16'h3FFF, 0, "R1 stack empty");
    idle(2);

    cfg(1, 0, 16'h8000, 16'h0800, 0, 3'b101, "R9 priv code");
    cfg(1, 1, 16'h9000, 16'h1000, 0, 3'b011, "R9 priv heap");
    cfg(1, 2, 16'h7000, 16'h0800, 1, 3'b011, "R9 priv stack");

    access(16'h0010, 0, "R3 code read");
    access(16'h0010, 2, "R6 code fetch");
    access(16'h0010, 1, "R6 code write denied");
    access(16'h07FF, 0, "R3 code last byte");
    access(16'h0800, 0, "R5 code off==size");
    access(16'h1FFF, 1, "R3 heap full size");
    access(16'h1000, 2, "R6 heap fetch denied");
    access(16'h1000, 3, "R6 acc 11 denied");
    access(16'h3C00, 0, "R4 stack down");
    access(16'h3800, 1, "R4 stack mag==size");
    access(16'h37FF, 0, "R5 stack mag>size");
    access(16'h3000, 0, "R5 stack off zero");
    access(16'h2000, 1, "R2 unmapped");
    access(16'h2FFF, 3, "R7 unmapped over prot");
    access(16'h0900, 1, "R7 bounds over prot");
    idle(1);
    access(16'h1234, 0, "R8 after gap");
    idle(3);

    cfg(0, 1, 16'h0000, 16'h0000, 1, 3'b000, "R9 user write");
    access(16'h1ABC, 1, "R9 heap kept");
    access(16'h1ABC, 2, "R9 heap prot kept");
    idle(2);
    cfg(1, 3, 16'h1111, 16'h0010, 1, 3'b111, "R10 sel3 write");
    access(16'h0100, 0, "R10 code kept");
    access(16'h3F00, 0, "R10 stack kept");
    idle(2);

    cfg(1, 1, 16'hF800, 16'h0A00, 0, 3'b111, "R9 heap reload");
    access(16'h1900, 2, "R3 heap wrap");
    access(16'h1A00, 0, "R5 heap new size");
    cfg(1, 2, 16'h0100, 16'h1000, 1, 3'b001, "R9 stack reload");
    access(16'h3C00, 0, "R4 stack wrap");
    access(16'h3000, 0, "R4 stack full size");
    access(16'h3000, 1, "R6 stack write denied");
    idle(4);

    check(sb_q.size() == 0, "R8 all responses seen", sb_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule